// File: doc/BRIEF.md
# Audio Serial Clock Source Selector

This block generates the bit clock and the word-select strobe for a two-channel serial audio output. Three references reach it as single-cycle tick enables, all sampled in one fast system clock: a master clock, a 22.5792 MHz crystal clock and a sample-rate clock. The references are free-running and unrelated to each other. Mode straps and the two-bit sample-rate code taken from the coded stream decide which reference drives the output and how far it is divided. The bit clock runs at 64 times the sample rate, so each channel gets 32 bit periods.

A four-state controller sequences the output. IDLE holds both strobes low while no usable reference is selected. SETTLE runs the bit clock with word-select held low for one whole frame. RUN produces normal frames. FAULT is entered on a forbidden strap set and is left only by reset. Transitions: IDLE to SETTLE when a valid selection appears. SETTLE to RUN on the last bit of the quiet frame. SETTLE or RUN back to SETTLE when the selection (reference and divisor) changes. Any non-fault state to IDLE when the selection becomes empty. Any state to FAULT on a forbidden strap set.

Top module: `aclk_sel_top`

## Requirements
- R1: With `mode_sel` equal to 2'b10 or 2'b11, the bit clock is taken from `fsref_tick` alone, with 4 ticks per bit-clock period when `ratio_384` is 0 and 6 ticks when it is 1.
- R2: With `mode_sel` 2'b00 and `sub_fsref` 1, the behaviour is the same as in R1, whatever the value of `mclk_24m`.
- R3: With `mode_sel` 2'b00 and `sub_fsref` 0 (automatic), rate code 2'b00 (44.1 kHz) selects `xtal_tick` at 8 ticks per period, 2'b01 (48 kHz) selects `mclk_tick` at 8 ticks, and 2'b10 (32 kHz) selects `mclk_tick` at 12 ticks.
- R4: Rate code 2'b11 in automatic mode, or `mode_sel` 2'b01, keeps `sck` and `ws` low.
- R5: The bit clock has equal high and low halves. `ws` changes only just after a falling edge of `sck`, and each level lasts 32 bit-clock periods.
- R6: After a change of reference or divisor, the divider restarts and `ws` stays low for one full 64-bit frame plus the following 32-bit left channel, so its first rise comes after 96 rising edges of `sck`.
- R7: In automatic mode, `ratio_384` = 1 or `mclk_24m` = 0 sets `cfg_err`. The flag stays set, with `sck` and `ws` low, until reset, even if the straps are corrected.
- R8: Outside automatic mode the rate code does not restart the output: `ws` keeps its cadence when the code changes.
- R9: While reset is applied, `sck`, `ws` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all reference ticks are sampled in it |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Configuration strap: 00 master input, 10/11 slave input, 01 unused |
| sub_fsref | input | 1 | Master sub-mode: 1 uses the sample-rate reference, 0 selects automatically |
| ratio_384 | input | 1 | Sample-rate reference is 384x fs when 1, 256x fs when 0 |
| mclk_24m | input | 1 | Master clock is 24.576 MHz when 1, 12.288 MHz when 0 |
| rate_code | input | 2 | Sample-rate code from the stream: 00 44.1k, 01 48k, 10 32k, 11 reserved |
| mclk_tick | input | 1 | One-cycle pulse per master clock period |
| xtal_tick | input | 1 | One-cycle pulse per crystal clock period |
| fsref_tick | input | 1 | One-cycle pulse per sample-rate reference period |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low for the left channel |
| cfg_err | output | 1 | Sticky forbidden-strap indication |

## Verification
The hardest state to reach is a selection change that lands partway through a running frame. A late restart here would leave a runt `ws` level or a short `sck` pulse. The stimulus reaches it by changing the straps or the rate code while RUN is active. It then counts `sck` rising edges until the first `ws` rise. The three tick streams have distinct spacings, so the measured period shows which reference was routed and with what divisor. A rate-code change in slave mode must leave the next `ws` edge on its original schedule.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int HALF_W = 3;

    // half bit-clock periods, counted in reference ticks
    localparam logic [HALF_W-1:0] HALF_256 = HALF_W'(2);
    localparam logic [HALF_W-1:0] HALF_384 = HALF_W'(3);
    localparam logic [HALF_W-1:0] HALF_512 = HALF_W'(4);
    localparam logic [HALF_W-1:0] HALF_768 = HALF_W'(6);

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_MCLK,
        SRC_XTAL,
        SRC_FSREF
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [HALF_W-1:0] half;
    } sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RUN,
        ST_FAULT
    } st_e;

endpackage

// File: rtl/aclk_route.sv
module aclk_route
    import aclk_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       sub_fsref,
    input  logic       ratio_384,
    input  logic       mclk_24m,
    input  logic [1:0] rate_code,
    input  logic       mclk_tick,
    input  logic       xtal_tick,
    input  logic       fsref_tick,
    output sel_t       sel,
    output logic       bad_strap,
    output logic       ref_tick
);

    logic fs_path;

    always_comb begin
        sel.src   = SRC_NONE;
        sel.half  = HALF_256;
        bad_strap = 1'b0;
        fs_path   = mode_sel[1] || (mode_sel == 2'b00 && sub_fsref);
        if (fs_path) begin
            sel.src  = SRC_FSREF;
            sel.half = ratio_384 ? HALF_384 : HALF_256;
        end else if (mode_sel == 2'b00) begin
            if (ratio_384 || !mclk_24m) begin
                bad_strap = 1'b1;
            end else begin
                unique case (rate_code)
                    2'b00: begin sel.src = SRC_XTAL; sel.half = HALF_512; end
                    2'b01: begin sel.src = SRC_MCLK; sel.half = HALF_512; end
                    2'b10: begin sel.src = SRC_MCLK; sel.half = HALF_768; end
                    default: sel.src = SRC_NONE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel.src)
            SRC_MCLK:  ref_tick = mclk_tick;
            SRC_XTAL:  ref_tick = xtal_tick;
            SRC_FSREF: ref_tick = fsref_tick;
            default:   ref_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/aclk_div.sv
module aclk_div
    import aclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic              tick,
    input  logic [HALF_W-1:0] half,
    output logic              sck,
    output logic              sck_fall
);

    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sck      <= 1'b0;
            sck_fall <= 1'b0;
        end else begin
            sck_fall <= 1'b0;
            if (clear || !run) begin
                cnt_q <= '0;
                sck   <= 1'b0;
            end else if (tick) begin
                if (cnt_q == half - HALF_W'(1)) begin
                    cnt_q    <= '0;
                    sck      <= ~sck;
                    sck_fall <= sck;
                end else begin
                    cnt_q <= cnt_q + HALF_W'(1);
                end
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && $stable(half)) |=> (cnt_q < half)); // R5

    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck); // R4

endmodule

// File: rtl/aclk_seq.sv
module aclk_seq
    import aclk_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic bad_strap,
    input  logic sck_fall,
    output logic div_run,
    output logic div_clear,
    output logic ws,
    output logic cfg_err
);

    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-2:0]   CH_LAST  = (BIT_W-1)'(FRAME_BITS/2 - 1);

    st_e              st_q, st_d;
    sel_t             cfg_q;
    logic [BIT_W-1:0] bit_q;
    logic             changed;
    logic             active;

    assign changed = (sel != cfg_q);
    assign active  = (st_q == ST_SETTLE) || (st_q == ST_RUN);

    // state register and next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FAULT: st_d = ST_FAULT;
            ST_IDLE: begin
                if (bad_strap)                 st_d = ST_FAULT;
                else if (sel.src != SRC_NONE)  st_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (bad_strap)                      st_d = ST_FAULT;
                else if (sel.src == SRC_NONE)       st_d = ST_IDLE;
                else if (changed)                   st_d = ST_SETTLE;
                else if (sck_fall && bit_q == LAST_BIT) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (bad_strap)                 st_d = ST_FAULT;
                else if (sel.src == SRC_NONE)  st_d = ST_IDLE;
                else if (changed)              st_d = ST_SETTLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cfg_q <= '{src: SRC_NONE, half: HALF_256};
        end else begin
            st_q  <= st_d;
            cfg_q <= sel;
        end
    end

    // outputs
    always_comb begin
        div_run   = active;
        div_clear = changed;
        cfg_err   = (st_q == ST_FAULT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            ws    <= 1'b0;
        end else if (changed || !active) begin
            bit_q <= '0;
            ws    <= 1'b0;
        end else if (sck_fall) begin
            bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + BIT_W'(1);
            if (st_q == ST_RUN && bit_q[BIT_W-2:0] == CH_LAST)
                ws <= ~ws;
        end
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R7

    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAULT) |-> !ws); // R7

    AST_SETTLE_WS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE) |-> !ws); // R6

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN && ws != $past(ws)) |-> $past(sck_fall)); // R5

endmodule

// File: rtl/aclk_sel_top.sv
module aclk_sel_top
    import aclk_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       sub_fsref,
    input  logic       ratio_384,
    input  logic       mclk_24m,
    input  logic [1:0] rate_code,
    input  logic       mclk_tick,
    input  logic       xtal_tick,
    input  logic       fsref_tick,
    output logic       sck,
    output logic       ws,
    output logic       cfg_err
);

    sel_t sel;
    logic bad_strap;
    logic ref_tick;
    logic div_run;
    logic div_clear;
    logic sck_fall;

    aclk_route u_route (
        .mode_sel   (mode_sel),
        .sub_fsref  (sub_fsref),
        .ratio_384  (ratio_384),
        .mclk_24m   (mclk_24m),
        .rate_code  (rate_code),
        .mclk_tick  (mclk_tick),
        .xtal_tick  (xtal_tick),
        .fsref_tick (fsref_tick),
        .sel        (sel),
        .bad_strap  (bad_strap),
        .ref_tick   (ref_tick)
    );

    aclk_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .bad_strap (bad_strap),
        .sck_fall  (sck_fall),
        .div_run   (div_run),
        .div_clear (div_clear),
        .ws        (ws),
        .cfg_err   (cfg_err)
    );

    aclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .clear    (div_clear),
        .tick     (ref_tick),
        .half     (sel.half),
        .sck      (sck),
        .sck_fall (sck_fall)
    );

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> !sck); // R7

endmodule

// File: tb/aclk_sel_top_test.sv
module aclk_sel_top_test;

    localparam int SP_M = 2;
    localparam int SP_X = 7;
    localparam int SP_F = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       sub_fsref, ratio_384, mclk_24m;
    logic [1:0] rate_code;
    logic       mclk_tick, xtal_tick, fsref_tick;
    logic       sck, ws, cfg_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cm = 0, cx = 0, cf = 0;

    typedef struct { int per; string tag; } exp_t;
    exp_t q[$];
    bit   mon_done;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        cm  <= (cm == SP_M-1) ? 0 : cm + 1;
        cx  <= (cx == SP_X-1) ? 0 : cx + 1;
        cf  <= (cf == SP_F-1) ? 0 : cf + 1;
    end
    assign mclk_tick  = (cm == 0);
    assign xtal_tick  = (cx == 0);
    assign fsref_tick = (cf == 0);

    aclk_sel_top uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sub_fsref(sub_fsref),
        .ratio_384(ratio_384), .mclk_24m(mclk_24m), .rate_code(rate_code),
        .mclk_tick(mclk_tick), .xtal_tick(xtal_tick), .fsref_tick(fsref_tick),
        .sck(sck), .ws(ws), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic s, input logic r,
                           input logic h, input logic [1:0] rc);
        @(negedge clk);
        mode_sel = m; sub_fsref = s; ratio_384 = r; mclk_24m = h; rate_code = rc;
    endtask

    task automatic wait_sck(input logic lvl, output int t);
        for (int i = 0; i < 4000 && sck == lvl; i++) @(negedge clk);
        for (int i = 0; i < 4000 && sck != lvl; i++) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_ws_edge(output int t);
        logic w0;
        w0 = ws;
        for (int i = 0; i < 40000 && ws == w0; i++) @(negedge clk);
        t = cyc;
    endtask

    // counts sck rising edges from a fresh selection until ws first rises
    task automatic settle_check(input string tag);
        int rises;
        logic prev;
        rises = 0;
        repeat (3) @(negedge clk);
        prev = sck;
        for (int i = 0; i < 20000 && !ws; i++) begin
            @(negedge clk);
            if (sck && !prev) rises++;
            prev = sck;
        end
        check(rises == 96, tag, rises, 96);
    endtask

    task automatic quiet_check(input string tag, input int len);
        int rises;
        int wsh;
        logic prev;
        rises = 0; wsh = 0;
        repeat (4) @(negedge clk);
        prev = sck;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (sck && !prev) rises++;
            if (ws) wsh++;
            prev = sck;
        end
        check(rises == 0, tag, rises, 0);
        check(wsh == 0, tag, wsh, 0);
    endtask

    task automatic expect_clock(input int per, input string tag);
        exp_t e;
        e.per = per; e.tag = tag;
        mon_done = 1'b0;
        q.push_back(e);
        wait (mon_done);
    endtask

    // monitor: pops an expectation and measures the running clocks
    initial begin
        exp_t e;
        int t0, t1, t2, w0, w1;
        forever begin
            wait (q.size() > 0);
            e = q.pop_front();
            wait_sck(1'b1, t0);
            wait_sck(1'b0, t1);
            wait_sck(1'b1, t2);
            check(t2 - t0 == e.per, {e.tag, " sck period"}, t2 - t0, e.per);
            check(2*(t1 - t0) == e.per, "R5 sck high half", t1 - t0, e.per/2);
            wait_ws_edge(w0);
            wait_ws_edge(w1);
            check(w1 - w0 == 32*e.per, "R5 ws level length", w1 - w0, 32*e.per);
            mon_done = 1'b1;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1;
        rst_n = 1'b0;
        mode_sel = 2'b10; sub_fsref = 1'b0; ratio_384 = 1'b0; mclk_24m = 1'b0; rate_code = 2'b00;
        repeat (5) @(negedge clk);
        check(sck == 1'b0, "R9 sck in reset", sck, 0);
        check(ws == 1'b0, "R9 ws in reset", ws, 0);
        check(cfg_err == 1'b0, "R9 cfg_err in reset", cfg_err, 0);
        rst_n = 1'b1;

        // R1 slave, 256x
        settle_check("R6 restart after reset");
        expect_clock(4*SP_F, "R1 slave 256x");
        // R8 rate code ignored in slave mode
        wait_ws_edge(t0);
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, 2'b01);
        wait_ws_edge(t1);
        check(t1 - t0 == 32*4*SP_F, "R8 ws cadence kept", t1 - t0, 32*4*SP_F);

        // R1 slave, 384x
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 2'b00);
        settle_check("R6 ratio change");
        expect_clock(6*SP_F, "R1 slave 384x");

        // R2 master, sample-rate reference
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 2'b10);
        settle_check("R6 mode change");
        expect_clock(4*SP_F, "R2 master fsref");

        // R3 automatic selection
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 2'b00);
        settle_check("R6 to crystal");
        expect_clock(8*SP_X, "R3 44.1k crystal");
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 2'b01);
        settle_check("R6 to master clock");
        expect_clock(8*SP_M, "R3 48k master");
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 2'b10);
        settle_check("R6 divisor change");
        expect_clock(12*SP_M, "R3 32k master");

        // R4 idle selections
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 2'b11);
        quiet_check("R4 reserved rate", 400);
        set_cfg(2'b01, 1'b0, 1'b0, 1'b1, 2'b00);
        quiet_check("R4 unused mode", 400);
        check(cfg_err == 1'b0, "R4 no error when idle", cfg_err, 0);

        // R7 forbidden straps
        set_cfg(2'b00, 1'b0, 1'b1, 1'b1, 2'b01);
        repeat (4) @(negedge clk);
        check(cfg_err == 1'b1, "R7 ratio strap error", cfg_err, 1);
        set_cfg(2'b00, 1'b0, 1'b0, 1'b1, 2'b01);
        quiet_check("R7 sticky silence", 400);
        check(cfg_err == 1'b1, "R7 error sticky", cfg_err, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 cleared by reset", cfg_err, 0);
        settle_check("R6 after error reset");
        expect_clock(8*SP_M, "R3 48k after reset");
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 2'b01);
        repeat (4) @(negedge clk);
        check(cfg_err == 1'b1, "R7 master strap error", cfg_err, 1);
        check(sck == 1'b0 && ws == 1'b0, "R7 outputs low", {sck, ws}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule